// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic down-counter, 24 bits wide by default, reached through a small 32-bit register port. Software programs a reload value and then sets the enable bit. The counter loads the reload value and counts down one step per tick. A tick is either every core clock cycle or only the cycles in which a synchronous reference-tick enable is high. When a step finds the counter at zero, the block expires: it sets a sticky wrap flag, emits a one-cycle interrupt pulse if interrupts are allowed, and then either reloads or stops.

Reads are combinational from `addr`. Any side effect of an access takes place at the clock edge on which `rd_en` or `wr_en` is sampled high. A write to the control or current-value register takes precedence over counting in that cycle. If a step expires in the same cycle as a control read, the expiry wins, so no wrap event is lost.

Top module: `sys_tick_timer`

## Requirements
- R1: The control register is at byte offset 0x10. Bit 0 is run (enable), bit 1 is interrupt allow, bit 2 is clock select, and bit 16 is the wrap flag. Only bits 2:0 are writable, and every other bit reads 0.
- R2: A read of the control register returns its current value, and the wrap flag clears at that same clock edge.
- R3: When run goes from 0 to 1, the counter loads the reload value. Each following tick decrements it by one, so one period is reload+1 ticks.
- R4: A tick that finds the counter at zero sets the wrap flag. If interrupt allow is 1, `irq` is high for exactly the one cycle after that edge; otherwise `irq` stays low.
- R5: If the reload value is 0 when the counter expires, run clears and counting stops. Otherwise the counter reloads and continues.
- R6: Any write to the current-value register (offset 0x18) loads the counter from the reload value and clears the wrap flag, whatever the data.
- R7: The current-value register reads 0 whenever run is 0.
- R8: The reload register (offset 0x14) stores the low 24 bits and reads 0 above them. The calibration register (offset 0x1C) reads the constant 10000.
- R9: A control write that keeps run at 1 but changes clock select restarts the count from the reload value.
- R10: Clock select 1 counts every core cycle. Clock select 0 counts only on cycles where `ref_tick` is high.
- R11: After reset every register reads 0 and `irq` is low.
- R12: Unmapped or non-word-aligned offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (carries the read side effect) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| ref_tick | input | 1 | Synchronous reference-tick enable |
| irq | output | 1 | One-cycle interrupt pending pulse |

## Verification
The counter is driven on the core clock with a large reload, so consecutive reads show single-step decrements. A reload of 3 with interrupts allowed places the pulse at exactly the fourth tick after enable. The same period is repeated with interrupts masked, which separates setting the wrap flag from raising the pulse. A zero reload shows the timer stopping after one tick instead of looping. In reference-tick mode the count is held while `ref_tick` stays low and then moves by exactly the number of ticks applied, which separates the two clock sources. The current-value write and the clock-select change are each applied mid-count, and both must bring the counter back to the reload value.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int CNT_W   = 24,
  parameter int ADDR_W  = 8,
  parameter int CAL_VAL = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ref_tick,
  output logic              irq
);

  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] W_CTRL = WW'(4);
  localparam logic [WW-1:0] W_RLD  = WW'(5);
  localparam logic [WW-1:0] W_CUR  = WW'(6);
  localparam logic [WW-1:0] W_CAL  = WW'(7);

  logic             run, tint, src, flag;
  logic [CNT_W-1:0] reload, cnt;

  logic [WW-1:0] word;
  logic          aligned, wr_ctrl, wr_cur, wr_rld, rd_ctrl, step, expire, restart;
  logic          unused_hi;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ctrl = wr_en && aligned && (word == W_CTRL);
  assign wr_rld  = wr_en && aligned && (word == W_RLD);
  assign wr_cur  = wr_en && aligned && (word == W_CUR);
  assign rd_ctrl = rd_en && aligned && (word == W_CTRL);
  assign step    = run && (src || ref_tick) && !wr_ctrl && !wr_cur;
  assign expire  = step && (cnt == '0);
  assign restart = wdata[0] && (!run || (wdata[2] != src));
  assign unused_hi = ^wdata[31:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      tint   <= 1'b0;
      src    <= 1'b0;
      flag   <= 1'b0;
      reload <= '0;
      cnt    <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= expire && tint;
      if (wr_rld) reload <= wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        {src, tint, run} <= wdata[2:0];
        if (restart) cnt <= reload;
      end else if (wr_cur) begin
        cnt <= reload;
      end else if (expire) begin
        if (reload == '0) run <= 1'b0;
        else              cnt <= reload;
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end
      if (expire)                 flag <= 1'b1;
      else if (rd_ctrl || wr_cur) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (word)
        W_CTRL:  rdata = {15'd0, flag, 13'd0, src, tint, run};
        W_RLD:   rdata = 32'(reload);
        W_CUR:   rdata = run ? 32'(cnt) : 32'd0;
        W_CAL:   rdata = 32'(CAL_VAL);
        default: rdata = '0;
      endcase
    end
  end

endmodule

module sys_tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              ref_tick,
  input logic              irq,
  input logic              run,
  input logic              src,
  input logic              flag,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload
);
  logic at_ctrl, at_cur, busy, ticking;
  assign at_ctrl = (addr == ADDR_W'(8'h10));
  assign at_cur  = (addr == ADDR_W'(8'h18));
  assign busy    = wr_en && (at_ctrl || at_cur);
  assign ticking = run && (src || ref_tick) && !busy;

  a_r6_cur_write_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_cur) |=> (!flag && cnt == $past(reload)));

  a_r3_single_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (ticking && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r5_zero_reload_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ticking && cnt == '0 && reload == '0) |=> !run);

  a_r4_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  a_r7_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && at_cur) |-> (rdata == 32'd0));

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src && !ref_tick && !busy) |=> $stable(cnt));
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .ref_tick(ref_tick), .irq(irq), .run(run), .src(src), .flag(flag),
  .cnt(cnt), .reload(reload)
);

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ref_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_tick_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ref_tick(ref_tick), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); check("R11 ctrl", v, 0);
    rd(A_RLD, v);  check("R11 reload", v, 0);
    rd(A_CUR, v);  check("R11 current", v, 0);
    check("R11 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, v);  check("R8 reload width", v, 32'h00FF_FFFF);
    rd(A_CAL, v);  check("R8 calibration", v, 32'd10000);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R1 writable bits", v, 32'h7);
    wr(A_CTRL, 0);
    rd(A_CUR, v);  check("R7 idle current", v, 0);
    rd(8'h00, v);  check("R12 unmapped", v, 0);
    rd(8'h11, v);  check("R12 misaligned", v, 0);
    wr(8'h15, 32'h55);
    rd(A_RLD, v);  check("R12 ignored write", v, 32'h00FF_FFFF);
  endtask

  task automatic t_decrement;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RLD, 100); wr(A_CTRL, 5);
    rd(A_CUR, v); check("R3 load", v, 100);
    rd(A_CUR, v); check("R3 step1", v, 99);
    rd(A_CUR, v); check("R10 core step2", v, 98);
  endtask

  task automatic t_period_irq;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RLD, 3); wr(A_CTRL, 7);
    idle(3); check("R4 no early irq", {31'd0, irq}, 0);
    idle(1); check("R4 irq at period", {31'd0, irq}, 1);
    idle(1); check("R4 irq one cycle", {31'd0, irq}, 0);
    rd(A_CTRL, v); check("R2 flag seen", v, 32'h0001_0007);
    rd(A_CTRL, v); check("R2 flag cleared", v, 32'h7);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    int seen = 0;
    wr(A_CTRL, 0); wr(A_RLD, 2); wr(A_CTRL, 5);
    for (int i = 0; i < 5; i++) begin
      idle(1);
      if (irq) seen++;
    end
    check("R4 masked irq", seen, 0);
    rd(A_CTRL, v); check("R4 masked flag", v, 32'h0001_0005);
  endtask

  task automatic t_zero_reload;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RLD, 0); wr(A_CTRL, 7);
    idle(1); check("R5 irq", {31'd0, irq}, 1);
    rd(A_CTRL, v); check("R5 stopped", v, 32'h0001_0006);
  endtask

  task automatic t_ref_tick;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RLD, 5); wr(A_CTRL, 1);
    idle(4);
    rd(A_CUR, v); check("R10 hold", v, 5);
    ref_tick = 1'b1; idle(2); ref_tick = 1'b0;
    rd(A_CUR, v); check("R10 ref steps", v, 3);
  endtask

  task automatic t_cur_write;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RLD, 9); wr(A_CTRL, 5);
    idle(12);
    wr(A_CUR, 32'd123);
    rd(A_CUR, v);  check("R6 reload", v, 9);
    rd(A_CTRL, v); check("R6 flag clear", v, 32'h5);
  endtask

  task automatic t_src_change;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_RLD, 9); wr(A_CTRL, 5);
    idle(4);
    wr(A_CTRL, 1);
    rd(A_CUR, v); check("R9 restart", v, 9);
    idle(3);
    rd(A_CUR, v); check("R9 hold after", v, 9);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset;
    t_fields;
    t_decrement;
    t_period_irq;
    t_masked;
    t_zero_reload;
    t_ref_tick;
    t_cur_write;
    t_src_change;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule